// File: doc/BRIEF.md
# SPI Master Transmit Sequencer

This block is the transmit side of an SPI master. Software sets an enable, then pushes 32-bit words through a one-cycle write strobe into a small FIFO. Whenever the engine is idle, enabled and the FIFO holds data, it takes the oldest word into a shift register and pulls chip select low. It then waits a programmed lead time before the first serial clock edge, shifts the word out most significant bit first in SPI mode 0, and raises chip select again. After that it keeps chip select high for at least a programmed idle gap before it starts the next frame.

The serial clock is derived from the system clock. Its half period is `half_div` system clocks. The lead time and the idle gap are given in whole serial clock periods. A FIFO fill count, a sticky overflow flag and a one-cycle transmit interrupt (or DMA request) pulse let software or a DMA engine keep the FIFO fed. The interrupt pulse fires when a load into the shift register brings the FIFO level down to the threshold.

Top module: `spi_tx_seq`

## Requirements
- R1: After synchronous active-low reset: `cs_n`=1, `sclk`=0, `busy`=0, `fifo_level`=0, `tx_irq`=0, `overflow`=0.
- R2: While `enable`=0 no frame starts and `cs_n` stays 1, but writes are still accepted into the FIFO.
- R3: Each accepted write stores the word at the FIFO write position. Words leave in the order written. `fifo_level` equals the number of buffered words, from 0 up to DEPTH (4).
- R4: A write while the FIFO is full is dropped, and `overflow` goes to 1 and stays 1 until reset.
- R5: Loading a word into the shift register lowers `fifo_level` by one in the same cycle that `cs_n` falls.
- R6: The first rising edge of `sclk` comes exactly lead×2×H system clocks after `cs_n` falls. Here lead is `lead_len`, H is `half_div`, and a field value of 0 counts as 1.
- R7: A frame has exactly 32 `sclk` rising edges. Data goes out MSB first on `mosi`, which is steady at each rising edge and changes only after falling edges. `sclk` is low whenever `cs_n` is high.
- R8: Between back-to-back frames `cs_n` stays high for exactly idle×2×H+1 system clocks. Here idle is `idle_len`, and 0 counts as 1.
- R9: `tx_irq` is a one-cycle pulse, raised when a load into the shift register brings `fifo_level` down to the threshold (0).
- R10: `busy` is 1 whenever `cs_n` is 0. It falls exactly idle×2×H system clocks after `cs_n` rises.
- R11: Successive `sclk` rising edges within a frame are 2×H system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows frames to start |
| wr_en | input | 1 | One-cycle write strobe for the FIFO |
| wr_data | input | 32 | Word to transmit |
| half_div | input | 8 | Serial clock half period in system clocks (0 counts as 1) |
| lead_len | input | 4 | Chip-select-to-clock delay in serial clock periods (0 counts as 1) |
| idle_len | input | 4 | Minimum deasserted time in serial clock periods (0 counts as 1) |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | High from chip select assertion until the idle gap ends |
| fifo_level | output | 3 | Number of buffered words |
| tx_irq | output | 1 | Transmit interrupt or DMA request pulse |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
The bench measures, from the ports only, the clock count from chip select falling to the first serial clock rise. It also measures the rise-to-rise spacing, the chip select high time between queued frames, and the `busy` tail. An off-by-one in any down-counter, or treating a zero field as zero, shows up as a wrong count. Words are checked for bit order and count, so a design that shifts LSB first, or one edge too early or too late, returns a wrong word or not 32 bits. The bench fills the FIFO past full while disabled, to catch a design that overwrites the oldest word or clears the overflow flag. It counts interrupt pulses over a three-word burst, to catch a design that fires on every load instead of only at the threshold.

// File: rtl/spi_tx_pkg.sv
// Package: shared types for the SPI transmit sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package spi_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } tx_state_e;
endpackage

// File: rtl/spi_tx_fifo.sv
// Module: synchronous transmit FIFO with a fill count and a sticky overflow flag.
// Assumes that push and pop are single-cycle strobes and that pop is only raised when not empty.
// A push into a full FIFO is dropped even if a pop happens in the same cycle.
module spi_tx_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              overflow
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              push_ok;

    assign full     = (level == LVL_W'(DEPTH));
    assign empty    = (level == '0);
    assign push_ok  = push && !full;
    assign pop_data = mem[rd_ptr];

    // Store an accepted word at the write position.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Advance pointers, track the fill count, latch overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop)
                level <= level + 1'b1;
            else if (!push_ok && pop)
                level <= level - 1'b1;
            if (push && full)
                overflow <= 1'b1;
        end
    end

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == LVL_W'(DEPTH)) && overflow);
endmodule

// File: rtl/spi_tx_timing.sv
// Module: converts the timing fields into system-clock counts.
// A field value of 0 counts as 1. Assumes the fields are held steady while a frame runs.
module spi_tx_timing #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 4,
    localparam int TW   = CNT_W + DIV_W + 1
) (
    input  logic [DIV_W-1:0] half_div,
    input  logic [CNT_W-1:0] lead_len,
    input  logic [CNT_W-1:0] idle_len,
    output logic [TW-1:0]    half_cyc,
    output logic [TW-1:0]    lead_cyc,
    output logic [TW-1:0]    gap_cyc
);
    logic [TW-1:0] half_e;
    logic [TW-1:0] lead_e;
    logic [TW-1:0] idle_e;

    // Clamp each field to a minimum of one.
    always_comb begin
        half_e = (half_div == '0) ? TW'(1) : TW'(half_div);
        lead_e = (lead_len == '0) ? TW'(1) : TW'(lead_len);
        idle_e = (idle_len == '0) ? TW'(1) : TW'(idle_len);
    end

    // Scale serial-clock periods into system clocks.
    always_comb begin
        half_cyc = half_e;
        lead_cyc = TW'((lead_e * half_e) << 1);
        gap_cyc  = TW'((idle_e * half_e) << 1);
    end
endmodule

// File: rtl/spi_tx_core.sv
// Module: frame sequencer and shift register.
// Sequence: load, lead delay, shift (mode 0, MSB first), idle gap.
// Assumes fifo_data is valid whenever fifo_empty is low.
module spi_tx_core
    import spi_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TW     = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic [TW-1:0]     half_cyc,
    input  logic [TW-1:0]     lead_cyc,
    input  logic [TW-1:0]     gap_cyc,
    output logic              pop,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              busy
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES);

    tx_state_e         state;
    logic [TW-1:0]     tcnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic [DATA_W-1:0] shreg;
    logic              tick;

    assign pop  = (state == ST_IDLE) && enable && !fifo_empty;
    assign busy = (state != ST_IDLE);
    assign mosi = shreg[DATA_W-1];
    assign tick = (tcnt <= TW'(1));

    // Frame state machine with one shared down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tcnt     <= '0;
            edge_cnt <= '0;
            sclk     <= 1'b0;
            cs_n     <= 1'b1;
            shreg    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pop) begin
                        shreg <= fifo_data;
                        cs_n  <= 1'b0;
                        tcnt  <= lead_cyc;
                        state <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        sclk     <= 1'b1;
                        edge_cnt <= EDGE_W'(1);
                        tcnt     <= half_cyc;
                        state    <= ST_SHIFT;
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (edge_cnt == EDGE_W'(EDGES - 1)) begin
                            sclk  <= 1'b0;
                            cs_n  <= 1'b1;
                            tcnt  <= gap_cyc;
                            state <= ST_GAP;
                        end else begin
                            sclk     <= ~sclk;
                            edge_cnt <= edge_cnt + 1'b1;
                            tcnt     <= half_cyc;
                            if (sclk) shreg <= {shreg[DATA_W-2:0], 1'b0};
                        end
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tick) state <= ST_IDLE;
                    else      tcnt  <= tcnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_sclk_low_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));
    p_busy_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);
    p_gap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);
endmodule

// File: rtl/spi_tx_seq.sv
// Module: top of the SPI master transmit sequencer.
// Ties the FIFO, the timing scaler and the frame core together, and makes the transmit interrupt pulse.
// Assumes the timing inputs are steady while a frame is in flight.
module spi_tx_seq #(
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 4,
    parameter int DIV_W     = 8,
    parameter int CNT_W     = 4,
    parameter int IRQ_LEVEL = 0,
    localparam int LVL_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [CNT_W-1:0]  lead_len,
    input  logic [CNT_W-1:0]  idle_len,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              busy,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              tx_irq,
    output logic              overflow
);
    localparam int TW = CNT_W + DIV_W + 1;

    logic              pop;
    logic              full;
    logic              empty;
    logic [DATA_W-1:0] head;
    logic [TW-1:0]     half_cyc;
    logic [TW-1:0]     lead_cyc;
    logic [TW-1:0]     gap_cyc;

    spi_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
        .pop(pop), .pop_data(head), .level(fifo_level), .full(full),
        .empty(empty), .overflow(overflow)
    );

    spi_tx_timing #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_timing (
        .half_div(half_div), .lead_len(lead_len), .idle_len(idle_len),
        .half_cyc(half_cyc), .lead_cyc(lead_cyc), .gap_cyc(gap_cyc)
    );

    spi_tx_core #(.DATA_W(DATA_W), .TW(TW)) u_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fifo_empty(empty),
        .fifo_data(head), .half_cyc(half_cyc), .lead_cyc(lead_cyc),
        .gap_cyc(gap_cyc), .pop(pop), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .busy(busy)
    );

    // Pulse the interrupt when a load drops the level to the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_irq <= 1'b0;
        else tx_irq <= pop && !(wr_en && !full)
                       && (fifo_level == LVL_W'(IRQ_LEVEL + 1));
    end

    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (fifo_level == LVL_W'(IRQ_LEVEL)));
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);
    p_load_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && !$past(wr_en)) |-> (fifo_level == $past(fifo_level) - 1'b1));
endmodule

// File: tb/spi_tx_seq_test.sv
// Directed bench for spi_tx_seq. A port monitor measures frames and timing, and each task checks its own scenario.
module spi_tx_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  half_div = 8'd2;
    logic [3:0]  lead_len = 4'd1;
    logic [3:0]  idle_len = 4'd1;
    logic        sclk, mosi, cs_n, busy, tx_irq, overflow;
    logic [2:0]  fifo_level;

    int checks = 0;
    int errors = 0;

    spi_tx_seq uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_data(wr_data), .half_div(half_div), .lead_len(lead_len),
        .idle_len(idle_len), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .busy(busy), .fifo_level(fifo_level), .tx_irq(tx_irq),
        .overflow(overflow)
    );

    always #5 clk = ~clk;

    // Port monitor, sampled on falling clock edges.
    int          cyc = 0;
    logic        p_cs = 1'b1, p_sclk = 1'b0, p_busy = 1'b0;
    int          cs_fall = 0, cs_rise = 0, last_rise = 0;
    int          lead_meas = 0, period_meas = 0, gap_meas = 0, busy_tail = 0;
    logic        first_rise = 1'b0;
    logic [31:0] cap = '0;
    int          bitcnt = 0, nframes = 0, irq_cnt = 0, bad_busy = 0;
    logic [31:0] got_words [16];
    int          got_bits [16];

    always @(negedge clk) begin
        cyc++;
        if (p_cs && !cs_n) begin
            if (nframes > 0) gap_meas = cyc - cs_rise;
            cs_fall = cyc; first_rise = 1'b1; bitcnt = 0;
        end
        if (!p_sclk && sclk) begin
            cap = {cap[30:0], mosi}; bitcnt++;
            if (first_rise) begin lead_meas = cyc - cs_fall; first_rise = 1'b0; end
            else period_meas = cyc - last_rise;
            last_rise = cyc;
        end
        if (!p_cs && cs_n) begin
            cs_rise = cyc;
            if (nframes < 16) begin got_words[nframes] = cap; got_bits[nframes] = bitcnt; end
            nframes++;
        end
        if (p_busy && !busy) busy_tail = cyc - cs_rise;
        if (tx_irq) irq_cnt++;
        if (!cs_n && !busy) bad_busy++;
        p_cs = cs_n; p_sclk = sclk; p_busy = busy;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while ((nframes < target || busy) && t < 20000) begin
            @(negedge clk); #1; t++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 cs_n/sclk", {cs_n, sclk}, 2'b10);
        chk(busy == 1'b0 && tx_irq == 1'b0, "R1 busy/irq", {busy, tx_irq}, 0);
        chk(fifo_level == 0 && overflow == 1'b0, "R1 level/ovf", {overflow, fifo_level}, 0);
    endtask

    task automatic t_disabled_then_single();
        int ib;
        half_div = 8'd2; lead_len = 4'd1; idle_len = 4'd1;
        push(32'hA5C3_0F81);
        repeat (100) @(negedge clk);
        #1;
        chk(cs_n == 1'b1 && nframes == 0, "R2 no frame while disabled", nframes, 0);
        chk(fifo_level == 3'd1, "R3 level after one write", fifo_level, 1);
        ib = irq_cnt;
        @(negedge clk); enable = 1'b1;
        wait_done(1);
        chk(got_words[0] == 32'hA5C3_0F81, "R7 word MSB first", got_words[0], 32'hA5C3_0F81);
        chk(got_bits[0] == 32, "R7 rising edges per frame", got_bits[0], 32);
        chk(lead_meas == 4, "R6 lead 1x2x2", lead_meas, 4);
        chk(period_meas == 4, "R11 sclk period", period_meas, 4);
        chk(busy_tail == 4, "R10 busy tail", busy_tail, 4);
        chk(bad_busy == 0, "R10 busy while cs low", bad_busy, 0);
        chk(irq_cnt - ib == 1, "R9 irq on last load", irq_cnt - ib, 1);
        chk(fifo_level == 0, "R5 level after load", fifo_level, 0);
    endtask

    task automatic t_back_to_back();
        int ib, base;
        @(negedge clk); enable = 1'b0;
        half_div = 8'd3; lead_len = 4'd2; idle_len = 4'd2;
        base = nframes;
        push(32'h1234_5678); push(32'h8000_0001); push(32'hDEAD_BEEF);
        #1;
        chk(fifo_level == 3'd3, "R3 level after three writes", fifo_level, 3);
        ib = irq_cnt;
        @(negedge clk); enable = 1'b1;
        while (cs_n) begin @(negedge clk); #1; end
        chk(fifo_level == 3'd2, "R5 level drops at cs fall", fifo_level, 2);
        wait_done(base + 3);
        chk(got_words[base] == 32'h1234_5678, "R3 order word0", got_words[base], 32'h1234_5678);
        chk(got_words[base+1] == 32'h8000_0001, "R3 order word1", got_words[base+1], 32'h8000_0001);
        chk(got_words[base+2] == 32'hDEAD_BEEF, "R3 order word2", got_words[base+2], 32'hDEAD_BEEF);
        chk(gap_meas == 13, "R8 cs high gap", gap_meas, 13);
        chk(lead_meas == 12, "R6 lead 2x2x3", lead_meas, 12);
        chk(period_meas == 6, "R11 sclk period", period_meas, 6);
        chk(busy_tail == 12, "R10 busy tail", busy_tail, 12);
        chk(irq_cnt - ib == 1, "R9 single irq for burst", irq_cnt - ib, 1);
    endtask

    task automatic t_overflow();
        int base;
        @(negedge clk); enable = 1'b0;
        half_div = 8'd1; lead_len = 4'd1; idle_len = 4'd1;
        base = nframes;
        for (int i = 0; i < 5; i++) push(32'hC0DE_0000 + i);
        #1;
        chk(fifo_level == 3'd4, "R3 level capped at depth", fifo_level, 4);
        chk(overflow == 1'b1, "R4 overflow set", overflow, 1);
        @(negedge clk); enable = 1'b1;
        wait_done(base + 4);
        repeat (50) @(negedge clk);
        #1;
        chk(nframes - base == 4, "R4 fifth word dropped", nframes - base, 4);
        chk(got_words[base+3] == 32'hC0DE_0003, "R4 oldest kept", got_words[base+3], 32'hC0DE_0003);
        chk(overflow == 1'b1, "R4 overflow sticky", overflow, 1);
    endtask

    task automatic t_zero_fields();
        int base;
        @(negedge clk); enable = 1'b0;
        half_div = 8'd0; lead_len = 4'd0; idle_len = 4'd0;
        base = nframes;
        push(32'h0000_FFFF); push(32'h5A5A_A5A5);
        @(negedge clk); enable = 1'b1;
        wait_done(base + 2);
        chk(got_words[base+1] == 32'h5A5A_A5A5, "R7 word at min divider", got_words[base+1], 32'h5A5A_A5A5);
        chk(lead_meas == 2, "R6 zero fields count as one", lead_meas, 2);
        chk(period_meas == 2, "R11 zero divider", period_meas, 2);
        chk(gap_meas == 3, "R8 zero idle", gap_meas, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled_then_single();
        t_back_to_back();
        t_overflow();
        t_zero_fields();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule